// File: doc/BRIEF.md
# Switch Injection Word Formatter

This block sits between a CPU-side byte source and the word-wide injection queue of a packet switch. For each frame it first takes a short descriptor: the payload length in bytes and the number of internal-header words that go in front of the payload. It then consumes header bytes followed by payload bytes, one byte per accepted beat, and packs them into 32-bit words. Each output word travels with a 32-bit control word that marks start of frame, end of frame, how many bytes of the last word are valid, and the inter-frame gap.

Frames that are too short for the queue's minimum cell are topped up with all-zero payload words until the cell is full. After the data and any padding, one all-zero word goes out as a stand-in for the frame check sequence, and that word carries the end-of-frame marking. The formatter does not start another frame until the stand-in word has left the output. Both stream edges use valid/ready handshakes, and a stalled output holds its word.

Top module: `inj_formatter`

## Requirements
- R1: While rst_ni is low and just after reset, out_valid_o and in_ready_o are 0 and frm_ready_o is 1.
- R2: A descriptor is taken on a cycle where frm_valid_i and frm_ready_o are both 1. frm_ready_o then stays 0 until the end-of-frame word has been transferred, and it returns to 1 on the cycle after that transfer.
- R3: The words of a frame are, in order, the header words and then ceil(len/4) payload words. They are packed big-endian from the input bytes, so the earliest byte goes in bits 31:24. The unused low bytes of a partial last word are zero.
- R4: When ceil(len/4) is below 15, all-zero words follow the payload until 15 payload-position words have been sent.
- R5: Exactly one all-zero word follows the payload and padding. This word ends the frame.
- R6: The control word uses bits 23:21 for the gap, bit 19 for end of frame, bit 18 for start of frame and bits 17:16 for valid bytes. All other bits are 0. The first word of a frame has start set and gap 1. The final word has end set and gap 1. Every other word has a control value of 0.
- R7: The valid-bytes field of the final word is 0 when len < 60. Otherwise it is len mod 4, where 0 means a full word.
- R8: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_data_o and out_ctrl_o keep their values. No word is lost or repeated.
- R9: A header-word count above 4 is treated as 4.
- R10: in_ready_o is 1 only while header or payload bytes of the current frame remain. No byte is taken while idle, padding or sending the end word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_valid_i | input | 1 | Frame descriptor valid |
| frm_ready_o | output | 1 | Descriptor accepted when high with valid |
| frm_len_i | input | LEN_W | Payload length in bytes |
| frm_hdr_words_i | input | HDR_W | Internal-header word count, saturated at MAX_HDR |
| in_valid_i | input | 1 | Byte valid |
| in_ready_o | output | 1 | Byte accepted when high with valid |
| in_data_i | input | 8 | Header then payload bytes |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Queue can take the word |
| out_data_o | output | 32 | Output data word |
| out_ctrl_o | output | 32 | Control word for the output word |

## Verification
The hardest case to reach is a byte that completes a word arriving while the output register is full and stalled. In that case in_ready_o must fall for that byte only, while bytes in the middle of a word keep flowing. The stimulus produces this case by combining random byte gaps with random output backpressure across many frames. It also reaches the frame-length boundaries at 56, 57, 59, 60 and 64 bytes, a frame with no header and no payload that is made up only of padding, and header counts above the limit.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int GAP_LSB = 21;
  localparam int GAP_W   = 3;
  localparam int EOF_BIT = 19;
  localparam int SOF_BIT = 18;
  localparam int VLD_LSB = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAD, ST_END} inj_st_e;

  function automatic logic [31:0] pack_ctrl(logic sof, logic eof, logic [1:0] vld,
                                            logic [GAP_W-1:0] gap);
    logic [31:0] w;
    w = '0;
    w[GAP_LSB +: GAP_W] = gap;
    w[EOF_BIT] = eof;
    w[SOF_BIT] = sof;
    w[VLD_LSB +: 2] = vld;
    return w;
  endfunction
endpackage

// File: rtl/inj_packer.sv
module inj_packer #(
  parameter int DW = 8,
  parameter int WW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] byte_i,
  input  logic          take_i,
  input  logic          flush_i,
  output logic [WW-1:0] word_o,
  output logic          last_lane_o
);
  localparam int LANES = WW / DW;
  localparam int IDX_W = $clog2(LANES);

  logic [IDX_W-1:0] idx_q;
  logic [WW-1:0]    acc_q;

  assign last_lane_o = (idx_q == IDX_W'(LANES - 1));

  // merge current byte into its big-endian lane
  always_comb begin
    word_o = acc_q;
    for (int l = 0; l < LANES; l++) begin
      if (idx_q == IDX_W'(l)) word_o[WW-1-l*DW -: DW] = byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (take_i) begin
      if (last_lane_o || flush_i) begin
        idx_q <= '0;
        acc_q <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
        acc_q <= word_o;
      end
    end
  end
endmodule

// File: rtl/inj_outreg.sv
module inj_outreg #(
  parameter int WW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] data_i,
  input  logic [31:0]   ctrl_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [WW-1:0] data_o,
  output logic [31:0]   ctrl_o,
  output logic          free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ctrl_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      ctrl_o  <= ctrl_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(ctrl_o));
endmodule

// File: rtl/inj_ctrl.sv
module inj_ctrl
  import inj_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int HDR_W     = 3,
  parameter int MAX_HDR   = 4,
  parameter int MIN_WORDS = 15,
  parameter int GAP_VAL   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_valid_i,
  input  logic [LEN_W-1:0] frm_len_i,
  input  logic [HDR_W-1:0] frm_hdr_i,
  output logic             frm_ready_o,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic             take_o,
  output logic             flush_o,
  input  logic             last_lane_i,
  input  logic             free_i,
  input  logic             out_valid_i,
  output logic             load_o,
  output logic             sel_pack_o,
  output logic [31:0]      ctrl_o
);
  localparam int MIN_BYTES = MIN_WORDS * 4;
  localparam int BL_W      = LEN_W + 1;
  localparam int WC_W      = LEN_W + 1;

  inj_st_e          st_q;
  logic [BL_W-1:0]  bleft_q;
  logic [WC_W-1:0]  wcnt_q, pad_end_q, wcnt_nxt;
  logic             first_q;
  logic [1:0]       vld_q;
  logic [HDR_W-1:0] hdr_eff;
  logic [BL_W-1:0]  total_bytes;
  logic             last_byte, word_last;

  assign hdr_eff     = (frm_hdr_i > HDR_W'(MAX_HDR)) ? HDR_W'(MAX_HDR) : frm_hdr_i;
  assign total_bytes = BL_W'({hdr_eff, 2'b00}) + BL_W'(frm_len_i);
  assign last_byte   = (bleft_q == BL_W'(1));
  assign word_last   = last_lane_i || last_byte;
  assign wcnt_nxt    = wcnt_q + WC_W'(1);

  assign frm_ready_o = (st_q == ST_IDLE) && !out_valid_i;
  // completing byte needs a free output slot; mid-word bytes do not
  assign in_ready_o  = (st_q == ST_DATA) && (!word_last || free_i);
  assign take_o      = in_ready_o && in_valid_i;
  assign flush_o     = last_byte;

  always_comb begin
    load_o     = 1'b0;
    sel_pack_o = 1'b0;
    ctrl_o     = '0;
    unique case (st_q)
      ST_DATA: begin
        load_o     = take_o && word_last;
        sel_pack_o = 1'b1;
        if (first_q) ctrl_o = pack_ctrl(1'b1, 1'b0, 2'b00, GAP_W'(GAP_VAL));
      end
      ST_PAD: begin
        load_o = free_i;
        if (first_q) ctrl_o = pack_ctrl(1'b1, 1'b0, 2'b00, GAP_W'(GAP_VAL));
      end
      ST_END: begin
        load_o = free_i;
        ctrl_o = pack_ctrl(1'b0, 1'b1, vld_q, GAP_W'(GAP_VAL));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bleft_q   <= '0;
      wcnt_q    <= '0;
      pad_end_q <= '0;
      first_q   <= 1'b0;
      vld_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (frm_valid_i && frm_ready_o) begin
          bleft_q   <= total_bytes;
          wcnt_q    <= '0;
          pad_end_q <= WC_W'(hdr_eff) + WC_W'(MIN_WORDS);
          first_q   <= 1'b1;
          vld_q     <= (frm_len_i < LEN_W'(MIN_BYTES)) ? 2'b00 : frm_len_i[1:0];
          st_q      <= (total_bytes == '0) ? ST_PAD : ST_DATA;
        end
        ST_DATA: begin
          if (take_o) bleft_q <= bleft_q - BL_W'(1);
          if (load_o) begin
            wcnt_q  <= wcnt_nxt;
            first_q <= 1'b0;
            if (last_byte) st_q <= (wcnt_nxt < pad_end_q) ? ST_PAD : ST_END;
          end
        end
        ST_PAD: if (load_o) begin
          wcnt_q  <= wcnt_nxt;
          first_q <= 1'b0;
          if (wcnt_nxt >= pad_end_q) st_q <= ST_END;
        end
        ST_END: if (load_o) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_pad_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PAD |-> wcnt_q < pad_end_q);
  assert_no_byte_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_ready_o |-> !take_o);
endmodule

// File: rtl/inj_formatter.sv
module inj_formatter
  import inj_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int HDR_W     = 3,
  parameter int MAX_HDR   = 4,
  parameter int MIN_WORDS = 15,
  parameter int GAP_VAL   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_valid_i,
  output logic             frm_ready_o,
  input  logic [LEN_W-1:0] frm_len_i,
  input  logic [HDR_W-1:0] frm_hdr_words_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [31:0]      out_data_o,
  output logic [31:0]      out_ctrl_o
);
  logic        take, flush, last_lane, free, load, sel_pack;
  logic [31:0] pack_word, ctrl_w, load_data;

  inj_packer #(.DW(8), .WW(32)) i_packer (
    .clk_i, .rst_ni,
    .byte_i      (in_data_i),
    .take_i      (take),
    .flush_i     (flush),
    .word_o      (pack_word),
    .last_lane_o (last_lane)
  );

  inj_ctrl #(
    .LEN_W(LEN_W), .HDR_W(HDR_W), .MAX_HDR(MAX_HDR),
    .MIN_WORDS(MIN_WORDS), .GAP_VAL(GAP_VAL)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .frm_valid_i, .frm_len_i,
    .frm_hdr_i   (frm_hdr_words_i),
    .frm_ready_o,
    .in_valid_i, .in_ready_o,
    .take_o      (take),
    .flush_o     (flush),
    .last_lane_i (last_lane),
    .free_i      (free),
    .out_valid_i (out_valid_o),
    .load_o      (load),
    .sel_pack_o  (sel_pack),
    .ctrl_o      (ctrl_w)
  );

  assign load_data = sel_pack ? pack_word : '0;

  inj_outreg #(.WW(32)) i_outreg (
    .clk_i, .rst_ni,
    .load_i  (load),
    .data_i  (load_data),
    .ctrl_i  (ctrl_w),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .ctrl_o  (out_ctrl_o),
    .free_o  (free)
  );

  assert_end_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ctrl_o[EOF_BIT] |-> out_data_o == '0);
  assert_sof_eof_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_ctrl_o[EOF_BIT] && out_ctrl_o[SOF_BIT]));
  assert_vld_only_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ctrl_o[EOF_BIT] |-> out_ctrl_o[VLD_LSB +: 2] == 2'b00);
  assert_busy_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !frm_ready_o);
endmodule

// File: tb/test_inj_formatter.sv
`timescale 1ns/1ps
module test_inj_formatter;
  localparam int LEN_W = 11;
  localparam int HDR_W = 3;
  localparam int NFRM  = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic frm_valid = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [LEN_W-1:0] frm_len = '0;
  logic [HDR_W-1:0] frm_hdr = '0;
  logic [7:0] in_data = '0;
  logic frm_ready, in_ready, out_valid;
  logic [31:0] out_data, out_ctrl;

  inj_formatter i_inj_formatter (
    .clk_i(clk), .rst_ni(rst_n),
    .frm_valid_i(frm_valid), .frm_ready_o(frm_ready),
    .frm_len_i(frm_len), .frm_hdr_words_i(frm_hdr),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_ctrl_o(out_ctrl)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  byte_q[$];
  logic [31:0] exp_d[$], exp_c[$];
  int          exp_k[$];

  int lens[NFRM] = '{0, 1, 3, 4, 5, 56, 57, 59, 60, 61, 62, 63, 64, 100, 2, 130};
  int hdrs[NFRM] = '{0, 2, 4, 1, 3, 0, 7, 4, 2, 5, 0, 1, 3, 4, 0, 6};

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(bit sof, bit eof, int vld);
    return (32'(1) << 21) | (32'(eof) << 19) | (32'(sof) << 18) | (32'(vld) << 16);
  endfunction

  // reference: queue the bytes to feed and the words expected at the output
  function automatic void build(int len, int hdr);
    logic [7:0] lq[$];
    int h, nw, pw, vld;
    logic [31:0] w;
    h = (hdr > 4) ? 4 : hdr;  // R9 saturation
    for (int i = 0; i < h * 4 + len; i++) lq.push_back(8'($urandom));
    foreach (lq[i]) byte_q.push_back(lq[i]);
    nw = (lq.size() + 3) / 4;
    for (int wi = 0; wi < nw; wi++) begin
      w = '0;
      for (int k = 0; k < 4; k++)
        if (wi * 4 + k < lq.size()) w |= 32'(lq[wi*4+k]) << (24 - 8 * k);
      exp_d.push_back(w);
      exp_c.push_back(wi == 0 ? mk_ctrl(1, 0, 0) : 32'h0);
      exp_k.push_back(0);
    end
    pw = (len + 3) / 4;
    for (int p = pw; p < 15; p++) begin
      exp_d.push_back('0);
      exp_c.push_back((nw == 0 && p == pw) ? mk_ctrl(1, 0, 0) : 32'h0);
      exp_k.push_back(1);
    end
    vld = (len < 60) ? 0 : len % 4;
    exp_d.push_back('0);
    exp_c.push_back(mk_ctrl(0, 1, vld));
    exp_k.push_back(2);
  endfunction

  initial begin
    int fi, cyc, k;
    bit busy, pend, hold;
    logic [31:0] hd, hc, d, c;
    string tg;
    fi = 0; cyc = 0; busy = 0; pend = 0; hold = 0; hd = '0; hc = '0;

    // R1 reset values
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(in_ready == 1'b0, "R1 in_ready", 32'(in_ready), 0);
    chk(frm_ready == 1'b1, "R1 frm_ready", 32'(frm_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && frm_ready == 1'b1, "R1 after release",
        {out_valid, frm_ready}, 32'h1);

    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "watchdog", 32'(cyc), 0);
        break;
      end
      if (fi == NFRM && !busy && exp_d.size() == 0) break;

      // drive
      out_ready = (fi < 6) ? 1'b1 : ($urandom % 5 < 3);
      frm_valid = 1'b0;
      if (!busy && fi < NFRM && ($urandom % 3 != 0 || pend)) begin
        pend = 1;
        frm_valid = 1'b1;
        frm_len = LEN_W'(lens[fi]);
        frm_hdr = HDR_W'(hdrs[fi]);
      end
      if (byte_q.size() > 0) begin
        in_valid = ($urandom % 4 != 0);
        in_data = byte_q[0];
      end else begin
        in_valid = 1'b1;  // junk must not be taken (R10)
        in_data = 8'hEE;
      end
      #1;

      // R8 stalled word held
      if (hold)
        chk(out_valid && out_data == hd && out_ctrl == hc, "R8 hold", out_data, hd);
      // R2 descriptor ready tracks model busy
      chk(frm_ready == !busy, "R2 frm_ready", 32'(frm_ready), 32'(!busy));
      // R10 no byte taken without one pending
      if (byte_q.size() == 0)
        chk(!(in_valid && in_ready), "R10 idle take", 32'(in_ready), 0);

      if (in_valid && in_ready && byte_q.size() > 0) void'(byte_q.pop_front());
      if (frm_valid && frm_ready) begin
        build(lens[fi], hdrs[fi]);
        busy = 1; pend = 0; fi++;
      end
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          chk(0, "R3 extra word", out_data, 0);
        end else begin
          d = exp_d.pop_front();
          c = exp_c.pop_front();
          k = exp_k.pop_front();
          tg = (k == 0) ? "R3 data" : (k == 1) ? "R4 pad" : "R5 end word";
          chk(out_data == d, tg, out_data, d);
          chk(out_ctrl == c, (k == 2) ? "R7 end ctrl" : "R6 ctrl", out_ctrl, c);
          if (k == 2) busy = 0;
        end
      end
      hold = out_valid && !out_ready;
      hd = out_data;
      hc = out_ctrl;
    end

    chk(exp_d.size() == 0, "R3 leftover words", 32'(exp_d.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule